// File: doc/BRIEF.md
# Dual-Source Serial Baud Tick Generator

This block produces the bit-rate sample tick for a serial port. The tick can be derived from either of two clock sources. Each source is represented inside the single clock domain of the block by an enable strobe. The main source is divided by a fixed factor of four. The crystal source is divided by three, or by two when a half-divide option is set. The prescaled pulses then drive a programmable divisor counter. That counter emits one tick every divisor-plus-one prescaled pulses.

Software writes one 32-bit setup word, which the block captures on a write strobe. It computes the divisor as the rounded quotient of the prescaled source frequency and the wanted bit rate, minus one. Useful rates run from 50 baud up to 4 Mbaud. A programmed divisor only takes effect while the enable bit of the word is set. Each write restarts the whole division chain from zero, so the first tick after a write comes exactly one full period later.

No data stream passes through this block, so it has no valid/ready handshake. The setup write, the two source strobes and the tick output are plain single-cycle control signals with no back-pressure.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the captured setup word is zero, `tick` is low, and no tick appears until a setup word with bit 23 set is written.
- R2: While bit 23 of the captured word is 0, `tick` stays low whatever the source strobes do.
- R3: With bit 24 = 0, only `main_en` pulses are counted (`xtal_en` is ignored), and one prescaled pulse results from every 4 counted pulses.
- R4: With bit 24 = 1 and bit 27 = 0, only `xtal_en` pulses are counted (`main_en` is ignored), and one prescaled pulse results from every 3 counted pulses.
- R5: With bit 24 = 1 and bit 27 = 1, one prescaled pulse results from every 2 `xtal_en` pulses; with bit 24 = 0, bit 27 has no effect.
- R6: Bits 22:0 hold the divisor D, and a tick is emitted on every (D+1)-th prescaled pulse; D = 0 gives a tick on every prescaled pulse.
- R7: `tick` is a one-cycle pulse that is high in the cycle after the clock edge that sampled the completing source strobe.
- R8: A write (`cfg_write` high) restarts the prescaler and divisor counts from zero, clears `tick` at that edge, and a source strobe sampled at the same edge is not counted.
- R9: Bits 25, 26 and 28 to 31 of the setup word have no effect on the tick train.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_write | input | 1 | Strobe that captures `cfg_value` and restarts counting |
| cfg_value | input | 32 | Setup word: divisor 22:0, enable 23, crystal select 24, half-divide 27 |
| main_en | input | 1 | One-cycle strobe per main source clock |
| xtal_en | input | 1 | One-cycle strobe per crystal source clock |
| tick | output | 1 | One-cycle baud sample tick |

## Verification
The setup write and the completion of a count can fall in the same cycle. This happens when `cfg_write` arrives together with a source strobe that would otherwise finish a prescaled period or a whole tick period. The bench provokes this with directed writes on a strobe-every-cycle train. It also issues random writes during random strobe activity. A bench model counts strobes since the last write and treats the write as the winner, so the colliding strobe is dropped and the next tick comes a full period after the write.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Setup word field positions (software-visible encoding)
  localparam int CFG_W       = 32;
  localparam int DIV_W       = 23;
  localparam int BIT_USE     = 23;
  localparam int BIT_XSEL    = 24;
  localparam int BIT_XHALF   = 27;

  // Fixed prescale factors of the two sources
  localparam int MAIN_PRE       = 4;
  localparam int XTAL_PRE       = 3;
  localparam int XTAL_HALF_PRE  = 2;
  localparam int PRE_MAX        = (MAIN_PRE > XTAL_PRE) ? MAIN_PRE : XTAL_PRE;
  localparam int PRE_W          = $clog2(PRE_MAX);

  typedef enum logic {SRC_MAIN = 1'b0, SRC_XTAL = 1'b1} src_e;

  typedef struct packed {
    logic              run;
    src_e              src;
    logic              half;
    logic [DIV_W-1:0]  divisor;
  } baud_cfg_t;

  function automatic baud_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    baud_cfg_t c;
    c.run     = w[BIT_USE];
    c.src     = src_e'(w[BIT_XSEL]);
    c.half    = w[BIT_XHALF];
    c.divisor = w[DIV_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/baud_src_select.sv
module baud_src_select
  import baud_pkg::*;
(
  input  src_e              src,
  input  logic              half,
  input  logic              main_en,
  input  logic              xtal_en,
  output logic              step,
  output logic [PRE_W-1:0]  last_phase
);
  localparam logic [PRE_W-1:0] MAIN_LAST  = PRE_W'(MAIN_PRE - 1);
  localparam logic [PRE_W-1:0] XTAL_LAST  = PRE_W'(XTAL_PRE - 1);
  localparam logic [PRE_W-1:0] XHALF_LAST = PRE_W'(XTAL_HALF_PRE - 1);

  always_comb begin
    if (src == SRC_XTAL) begin
      step       = xtal_en;
      last_phase = half ? XHALF_LAST : XTAL_LAST;
    end else begin
      step       = main_en;
      last_phase = MAIN_LAST;
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] last_phase,
  output logic         wrap
);
  logic [W-1:0] phase;

  assign wrap = run && !restart && step && (phase == last_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart || !run) begin
      phase <= '0;
    end else if (step) begin
      if (phase == last_phase) phase <= '0;
      else                     phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] count;
  logic         done;

  assign done = run && !restart && step && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= done;
      if (restart || !run) begin
        count <= '0;
      end else if (step) begin
        if (count == limit) count <= '0;
        else                count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_write,
  input  logic [31:0] cfg_value,
  input  logic        main_en,
  input  logic        xtal_en,
  output logic        tick
);
  logic [CFG_W-1:0] cfg_q;
  baud_cfg_t        cfg;
  logic             src_step;
  logic [PRE_W-1:0] last_phase;
  logic             pre_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (cfg_write) cfg_q <= cfg_value;
  end

  assign cfg = decode_cfg(cfg_q);

  baud_src_select u_sel (
    .src        (cfg.src),
    .half       (cfg.half),
    .main_en    (main_en),
    .xtal_en    (xtal_en),
    .step       (src_step),
    .last_phase (last_phase)
  );

  baud_prescaler #(.W(PRE_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (cfg_write),
    .run        (cfg.run),
    .step       (src_step),
    .last_phase (last_phase),
    .wrap       (pre_wrap)
  );

  baud_divider #(.W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_write),
    .run     (cfg.run),
    .step    (pre_wrap),
    .limit   (cfg.divisor),
    .tick    (tick)
  );
endmodule

// File: rtl/baud_tick_checker.sv
module baud_tick_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_write,
  input logic        main_en,
  input logic        xtal_en,
  input logic [31:0] cfg_q,
  input logic        tick
);
  assert_no_tick_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[23] |-> !tick);

  assert_main_strobe_before_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_q[24]) |-> $past(main_en));

  assert_xtal_strobe_before_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg_q[24]) |-> $past(xtal_en));

  assert_tick_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_write_clears_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_write) |-> !tick);
endmodule

bind baud_tick_gen baud_tick_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_write (cfg_write),
  .main_en   (main_en),
  .xtal_en   (xtal_en),
  .cfg_q     (cfg_q),
  .tick      (tick)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_write = 1'b0;
  logic [31:0] cfg_value = '0;
  logic        main_en = 1'b0;
  logic        xtal_en = 1'b0;
  logic        tick;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;

  logic [31:0] m_cfg = '0;
  longint      m_cnt = 0;
  bit          m_exp = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_write(cfg_write), .cfg_value(cfg_value),
    .main_en(main_en), .xtal_en(xtal_en), .tick(tick)
  );

  function automatic longint period_of(input logic [31:0] c);
    longint pre;
    if (c[24]) pre = c[27] ? 2 : 3;
    else       pre = 4;
    return pre * (longint'(c[22:0]) + 1);
  endfunction

  function automatic string tag_of(input logic [31:0] c, input bit w);
    if (w)          return "R8";
    if (!c[23])     return "R2";
    if (c[24] && c[27]) return "R5";
    if (c[24])      return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive after negedge, model at posedge, compare at next negedge
  task automatic step(input bit w, input logic [31:0] v, input bit m, input bit x);
    string tg;
    cfg_write = w; cfg_value = v; main_en = m; xtal_en = x;
    @(posedge clk);
    if (w) begin
      m_cfg = v; m_cnt = 0; m_exp = 1'b0;
    end else if (m_cfg[23] && (m_cfg[24] ? x : m)) begin
      m_cnt++;
      m_exp = ((m_cnt % period_of(m_cfg)) == 0);
    end else begin
      m_exp = 1'b0;
    end
    tg = tag_of(m_cfg, w);
    @(negedge clk);
    check(tg, tick, m_exp);
  endtask

  task automatic count_ticks(input int n, input bit m, input bit x, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, cfg_value, m, x);
      cnt += tick;
    end
  endtask

  initial begin
    int unsigned seed;
    int c;
    int c2;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1", tick, 0);
    rst_n = 1'b1;
    // R1: idle after reset, strobes on both sources, no ticks expected
    for (int i = 0; i < 20; i++) step(1'b0, '0, 1'b1, 1'b1);

    // R3 / R6: main source, D=0, strobe every cycle -> 10 ticks in 40 cycles
    step(1'b1, 32'h0080_0000, 1'b0, 1'b0);
    count_ticks(40, 1'b1, 1'b0, c);
    check("R6", c, 10);
    // R3: crystal strobes ignored on main source
    step(1'b1, 32'h0080_0000, 1'b0, 1'b0);
    count_ticks(40, 1'b0, 1'b1, c);
    check("R3", c, 0);
    // R4: crystal /3, D=1 -> period 6, 48 cycles -> 8 ticks
    step(1'b1, 32'h0180_0001, 1'b0, 1'b0);
    count_ticks(48, 1'b0, 1'b1, c);
    check("R4", c, 8);
    // R5: crystal /2, D=2 -> period 6; bit27 on main keeps /4
    step(1'b1, 32'h0980_0002, 1'b0, 1'b0);
    count_ticks(48, 1'b0, 1'b1, c);
    check("R5", c, 8);
    step(1'b1, 32'h0880_0000, 1'b0, 1'b0);
    count_ticks(40, 1'b1, 1'b0, c);
    check("R5", c, 10);
    // R2: enable bit clear
    step(1'b1, 32'h0100_0000, 1'b0, 1'b0);
    count_ticks(40, 1'b1, 1'b1, c);
    check("R2", c, 0);
    // R9: junk in spare bits gives same train
    step(1'b1, 32'h0180_0003, 1'b0, 1'b0);
    count_ticks(60, 1'b1, 1'b1, c);
    step(1'b1, 32'hF680_0003 | 32'h0100_0000, 1'b0, 1'b0);
    count_ticks(60, 1'b1, 1'b1, c2);
    check("R9", c2, c);
    // R8: write collides with a completing strobe; next tick a full period later
    step(1'b1, 32'h0080_0000, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 32'h0080_0000, 1'b1, 1'b0);
    step(1'b1, 32'h0080_0000, 1'b1, 1'b0);
    check("R8", tick, 0);
    count_ticks(3, 1'b1, 1'b0, c);
    check("R8", c, 0);
    count_ticks(1, 1'b1, 1'b0, c);
    check("R8", c, 1);
    // R6: larger divisor, period 4*50=200
    step(1'b1, 32'h0080_0031, 1'b0, 1'b0);
    count_ticks(400, 1'b1, 1'b0, c);
    check("R6", c, 2);

    // Random phase with sparse/dense strobes and random rewrites (R7, R8 collisions)
    for (int s = 0; s < 40; s++) begin
      logic [31:0] v;
      int dm, dx;
      v = $urandom;
      v[22:0] = 23'($urandom_range(0, 5));
      v[23] = ($urandom_range(0, 9) != 0);
      dm = $urandom_range(1, 4);
      dx = $urandom_range(1, 4);
      step(1'b1, v, $urandom_range(0, 1), $urandom_range(0, 1));
      for (int i = 0; i < 300; i++) begin
        bit w;
        w = ($urandom_range(0, 199) == 0);
        step(w, w ? (v ^ {9'($urandom), 23'd0}) : cfg_value,
             ($urandom_range(1, dm) == 1), ($urandom_range(1, dx) == 1));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule